// File: doc/BRIEF.md
# Sub-word register access adapter

This block sits between a 128-byte little-endian I/O window and register banks that only take aligned 32-bit accesses. A host presents one request at a time: an offset inside the window, a width of 1, 2 or 4 bytes, a direction and, for writes, right-aligned write data. The adapter sends each request to one of three places. The first is a bank of core registers at the bottom of the window. The second is a bank of DMA registers above it. The third is a single 32-bit bus/control register, which the adapter holds itself.

A write that is 4 bytes wide and 4-byte aligned passes straight through as one write strobe. Any narrower write becomes a read-modify-write. The adapter pulses a one-cycle read strobe and takes the current word. It then replaces only the addressed byte lanes and pulses a one-cycle write strobe with the merged word. A read always fetches the full word. It returns only the requested bytes, shifted down to bit 0 and zero above the access width. An access that would cross a 32-bit boundary, or that has a width other than 1, 2 or 4, is refused with an error response.

Top module: `subword_adapter`

## Requirements
- R1: After reset, busy, rsp_valid, rsp_err and all four bank strobes are low, and the bus/control register reads as 0.
- R2: A write that is 4 bytes wide at an offset whose low two bits are 0 produces exactly one write strobe, in the cycle after it is accepted. That strobe carries the write data unchanged, and no read strobe occurs.
- R3: Any other valid write produces one read strobe in the cycle after it is accepted, then one write strobe in the next cycle. Byte k of the write data (k from 0) replaces bits [8(o+k)+7 : 8(o+k)] of the current word, where o is the offset's low two bits. All other bits keep their current value.
- R4: A read returns rsp_rdata equal to the addressed word shifted right by 8·o and masked to 8·size bits, with rsp_valid high for one cycle.
- R5: Offsets 0x00 to 0x3F select the core bank with index = offset>>2 on tgt_idx.
- R6: Offsets 0x40 to 0x5F select the DMA bank with index = (offset−0x40)>>2 on tgt_idx.
- R7: Offset word 0x70 is the internal 32-bit bus/control register. It is written and read in full or by byte lanes, with no bank strobe.
- R8: Writes to offsets 0x60–0x6F and 0x74–0x7F change nothing and pulse no strobe. Reads there return 0.
- R9: A request with width not in {1,2,4}, or with o+width > 4, gives rsp_valid with rsp_err high in the cycle after acceptance. It pulses no strobe and changes no register.
- R10: busy is high from the cycle after acceptance until the response, and every strobe falls inside that period. Requests presented while busy is high are ignored. Each accepted request gives exactly one rsp_valid pulse, and busy is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte offset within the window |
| req_size | input | 3 | Access width in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Right-aligned write data |
| busy | output | 1 | Sequence in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request refused (bad width or crossing) |
| rsp_rdata | output | 32 | Right-aligned read data, zero when not a read response |
| core_rd | output | 1 | Read strobe to core bank |
| core_wr | output | 1 | Write strobe to core bank |
| dma_rd | output | 1 | Read strobe to DMA bank |
| dma_wr | output | 1 | Write strobe to DMA bank |
| tgt_idx | output | 4 | Word index in the selected bank |
| tgt_wdata | output | 32 | Full word written with a write strobe |
| core_rdata | input | 32 | Core bank word at tgt_idx, valid while core_rd is high |
| dma_rdata | input | 32 | DMA bank word at tgt_idx, valid while dma_rd is high |

## Verification
The assertions assume that each bank returns the word at tgt_idx on its read-data input, without delay, in the same cycle as its read strobe. They also assume that the host holds nothing else on the request bus while busy is low except a request it means to issue. The bench models both banks as plain word arrays indexed by tgt_idx and returns read data combinationally, so the first assumption holds. It drives requests on the falling edge and drops req_valid after one cycle, except in the deliberate busy-collision scenario. There the second request is removed before the adapter returns to idle.

// File: rtl/subword_pkg.sv
package subword_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_STORE = 2'd2
    } seq_e;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_CORE = 2'd1,
        DST_DMA  = 2'd2,
        DST_CTRL = 2'd3
    } dst_e;

endpackage

// File: rtl/subword_decode.sv
module subword_decode
    import subword_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int IDX_W       = 4,
    parameter int WORD_BYTES  = 4,
    parameter int CORE_LIMIT  = 'h40,
    parameter int DMA_LIMIT   = 'h60,
    parameter int CTRL_OFFSET = 'h70
) (
    input  logic [ADDR_W-1:0] byte_addr,
    output dst_e              dst,
    output logic [IDX_W-1:0]  idx
);
    localparam int LANE_W = $clog2(WORD_BYTES);

    logic [ADDR_W-1:0] word_addr;
    logic [ADDR_W-1:0] rel_addr;

    always_comb begin
        word_addr = {byte_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
        rel_addr  = '0;
        dst       = DST_NONE;
        if (int'(word_addr) < CORE_LIMIT) begin
            dst      = DST_CORE;
            rel_addr = word_addr;
        end else if (int'(word_addr) < DMA_LIMIT) begin
            dst      = DST_DMA;
            rel_addr = word_addr - ADDR_W'(CORE_LIMIT);
        end else if (int'(word_addr) == CTRL_OFFSET) begin
            dst      = DST_CTRL;
        end
        idx = IDX_W'(rel_addr >> LANE_W);
    end

endmodule

// File: rtl/subword_lanes.sv
module subword_lanes #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 2,
    parameter int SIZE_W = 3
) (
    input  logic [DATA_W-1:0] cur_word,
    input  logic [DATA_W-1:0] new_data,
    input  logic [LANE_W-1:0] lane_off,
    input  logic [SIZE_W-1:0] nbytes,
    output logic [DATA_W-1:0] merged,
    output logic [DATA_W-1:0] extracted
);
    localparam int NBYTE = DATA_W / 8;

    logic [DATA_W-1:0] placed;
    logic [DATA_W-1:0] lowered;

    assign placed  = new_data << (8 * lane_off);
    assign lowered = cur_word >> (8 * lane_off);

    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        logic hit;
        assign hit = (b >= int'(lane_off)) && (b < int'(lane_off) + int'(nbytes));
        assign merged[8*b +: 8]    = hit ? placed[8*b +: 8] : cur_word[8*b +: 8];
        assign extracted[8*b +: 8] = (b < int'(nbytes)) ? lowered[8*b +: 8] : 8'h00;
    end

endmodule

// File: rtl/subword_adapter.sv
module subword_adapter
    import subword_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 32,
    parameter int IDX_W       = 4,
    parameter int CORE_LIMIT  = 'h40,
    parameter int DMA_LIMIT   = 'h60,
    parameter int CTRL_OFFSET = 'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              core_rd,
    output logic              core_wr,
    output logic              dma_rd,
    output logic              dma_wr,
    output logic [IDX_W-1:0]  tgt_idx,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic [DATA_W-1:0] core_rdata,
    input  logic [DATA_W-1:0] dma_rdata
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int LANE_W     = $clog2(WORD_BYTES);

    typedef struct packed {
        seq_e              seq;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        size;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] ctrl;
        logic              rvalid;
        logic              rerr;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    localparam regs_t REGS_RESET = '{
        seq: SEQ_IDLE, write: 1'b0, addr: '0, size: '0, data: '0,
        ctrl: '0, rvalid: 1'b0, rerr: 1'b0, rdata: '0
    };

    regs_t r_q, r_d;

    dst_e              dst;
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] extracted;
    logic [LANE_W-1:0] req_off;
    logic              size_ok;
    logic              fits;
    logic              whole;

    subword_decode #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES),
        .CORE_LIMIT(CORE_LIMIT), .DMA_LIMIT(DMA_LIMIT), .CTRL_OFFSET(CTRL_OFFSET)
    ) decode_i (
        .byte_addr(r_q.addr),
        .dst      (dst),
        .idx      (tgt_idx)
    );

    subword_lanes #(
        .DATA_W(DATA_W), .LANE_W(LANE_W), .SIZE_W(3)
    ) lanes_i (
        .cur_word (cur_word),
        .new_data (r_q.data),
        .lane_off (r_q.addr[LANE_W-1:0]),
        .nbytes   (r_q.size),
        .merged   (merged),
        .extracted(extracted)
    );

    always_comb begin
        unique case (dst)
            DST_CORE: cur_word = core_rdata;
            DST_DMA:  cur_word = dma_rdata;
            DST_CTRL: cur_word = r_q.ctrl;
            default:  cur_word = '0;
        endcase
    end

    assign req_off = req_addr[LANE_W-1:0];
    assign size_ok = (req_size == 3'd1) || (req_size == 3'd2) ||
                     (int'(req_size) == WORD_BYTES);
    assign fits    = (int'(req_off) + int'(req_size)) <= WORD_BYTES;
    assign whole   = (int'(req_size) == WORD_BYTES) && (req_off == '0);

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        r_d.rerr   = 1'b0;
        r_d.rdata  = '0;
        unique case (r_q.seq)
            SEQ_IDLE: begin
                if (req_valid) begin
                    r_d.write = req_write;
                    r_d.addr  = req_addr;
                    r_d.size  = req_size;
                    r_d.data  = req_wdata;
                    if (!size_ok || !fits) begin
                        r_d.rvalid = 1'b1;
                        r_d.rerr   = 1'b1;
                    end else if (req_write && whole) begin
                        r_d.seq = SEQ_STORE;
                    end else begin
                        r_d.seq = SEQ_FETCH;
                    end
                end
            end
            SEQ_FETCH: begin
                if (r_q.write) begin
                    r_d.data = merged;
                    r_d.seq  = SEQ_STORE;
                end else begin
                    r_d.rdata  = extracted;
                    r_d.rvalid = 1'b1;
                    r_d.seq    = SEQ_IDLE;
                end
            end
            SEQ_STORE: begin
                if (dst == DST_CTRL) begin
                    r_d.ctrl = r_q.data;
                end
                r_d.rvalid = 1'b1;
                r_d.seq    = SEQ_IDLE;
            end
            default: r_d.seq = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.seq != SEQ_IDLE);
    assign rsp_valid = r_q.rvalid;
    assign rsp_err   = r_q.rerr;
    assign rsp_rdata = r_q.rdata;
    assign core_rd   = (r_q.seq == SEQ_FETCH) && (dst == DST_CORE);
    assign dma_rd    = (r_q.seq == SEQ_FETCH) && (dst == DST_DMA);
    assign core_wr   = (r_q.seq == SEQ_STORE) && (dst == DST_CORE);
    assign dma_wr    = (r_q.seq == SEQ_STORE) && (dst == DST_DMA);
    assign tgt_wdata = r_q.data;

endmodule

module subword_adapter_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              core_rd,
    input logic              core_wr,
    input logic              dma_rd,
    input logic              dma_wr
);
    // R10
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_rd, core_wr, dma_rd, dma_wr}));

    // R10
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd || core_wr || dma_rd || dma_wr) |-> busy);

    // R10
    rsp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy);

    // R2
    write_then_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr || dma_wr) |=> (rsp_valid && !rsp_err));

    // R3
    fetch_leaves_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd || dma_rd) |=> (busy || rsp_valid));

    // R9
    err_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    // R9
    err_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !$past(busy));

    // R4
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_rdata == '0));

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid || !$past(busy, 2) || $past(req_valid));

endmodule

bind subword_adapter subword_adapter_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .busy     (busy),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .core_rd  (core_rd),
    .core_wr  (core_wr),
    .dma_rd   (dma_rd),
    .dma_wr   (dma_wr)
);

// File: tb/subword_adapter_tb.sv
module subword_adapter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        core_rd, core_wr, dma_rd, dma_wr;
    logic [3:0]  tgt_idx;
    logic [31:0] tgt_wdata, core_rdata, dma_rdata;

    logic [31:0] core_mem [16];
    logic [31:0] dma_mem  [8];
    int rd_total = 0;
    int wr_total = 0;
    int busy_total = 0;
    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    subword_adapter dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .core_rd(core_rd), .core_wr(core_wr), .dma_rd(dma_rd), .dma_wr(dma_wr),
        .tgt_idx(tgt_idx), .tgt_wdata(tgt_wdata),
        .core_rdata(core_rdata), .dma_rdata(dma_rdata)
    );

    assign core_rdata = core_mem[tgt_idx];
    assign dma_rdata  = dma_mem[tgt_idx[2:0]];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) core_mem[i] <= 32'h0;
            for (int i = 0; i < 8; i++)  dma_mem[i]  <= 32'h0;
        end else begin
            if (core_wr) core_mem[tgt_idx] <= tgt_wdata;
            if (dma_wr)  dma_mem[tgt_idx[2:0]] <= tgt_wdata;
            if (core_rd || dma_rd) rd_total <= rd_total + 1;
            if (core_wr || dma_wr) wr_total <= wr_total + 1;
            if (busy) busy_total <= busy_total + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_merge(input logic [31:0] cur, input logic [31:0] nd,
                                              input int off, input int sz);
        logic [31:0] r = cur;
        for (int k = 0; k < sz; k++) r[8*(off+k) +: 8] = nd[8*k +: 8];
        return r;
    endfunction

    function automatic logic [31:0] ref_pick(input logic [31:0] w, input int off, input int sz);
        logic [31:0] r = '0;
        for (int k = 0; k < sz; k++) r[8*k +: 8] = w[8*(off+k) +: 8];
        return r;
    endfunction

    logic [31:0] got_data;
    logic        got_err;
    int          got_rd, got_wr;

    task automatic access(input bit wr, input logic [6:0] a, input logic [2:0] sz,
                          input logic [31:0] wd);
        int rd0 = rd_total;
        int wr0 = wr_total;
        int n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(rsp_valid, "R10 response", 32'(rsp_valid), 32'h1);
        got_data = rsp_rdata;
        got_err  = rsp_err;
        @(negedge clk);
        check(!rsp_valid, "R10 single pulse", 32'(rsp_valid), 32'h0);
        got_rd = rd_total - rd0;
        got_wr = wr_total - wr0;
    endtask

    task automatic t_reset();
        check(!busy && !rsp_valid && !rsp_err, "R1 idle outputs", {busy, rsp_valid, rsp_err}, 0);
        check(!(core_rd | core_wr | dma_rd | dma_wr), "R1 strobes",
              {core_rd, core_wr, dma_rd, dma_wr}, 0);
        access(1'b0, 7'h70, 3'd4, 0);
        check(got_data == 32'h0, "R1 ctrl reset", got_data, 32'h0);
    endtask

    task automatic t_full_write();
        access(1'b1, 7'h0C, 3'd4, 32'hDEADBEEF);
        check(got_rd == 0 && got_wr == 1, "R2 strobe count", 32'(got_rd*16 + got_wr), 32'h1);
        check(core_mem[3] == 32'hDEADBEEF, "R2 R5 core word 3", core_mem[3], 32'hDEADBEEF);
        access(1'b1, 7'h3C, 3'd4, 32'h0BADF00D);
        check(core_mem[15] == 32'h0BADF00D, "R5 core top index", core_mem[15], 32'h0BADF00D);
    endtask

    task automatic t_narrow_write();
        logic [31:0] e;
        e = ref_merge(32'hDEADBEEF, 32'h55, 1, 1);
        access(1'b1, 7'h0D, 3'd1, 32'hFFFFFF55);
        check(got_rd == 1 && got_wr == 1, "R3 rmw strobes", 32'(got_rd*16 + got_wr), 32'h11);
        check(core_mem[3] == e, "R3 byte merge", core_mem[3], e);
        e = ref_merge(e, 32'h1234, 2, 2);
        access(1'b1, 7'h0E, 3'd2, 32'hABCD1234);
        check(core_mem[3] == e, "R3 half merge", core_mem[3], e);
    endtask

    task automatic t_reads();
        logic [31:0] w;
        w = core_mem[3];
        access(1'b0, 7'h0F, 3'd1, 0);
        check(got_data == ref_pick(w, 3, 1), "R4 byte read", got_data, ref_pick(w, 3, 1));
        check(got_rd == 1 && got_wr == 0, "R4 read strobes", 32'(got_rd*16 + got_wr), 32'h10);
        access(1'b0, 7'h0D, 3'd2, 0);
        check(got_data == ref_pick(w, 1, 2), "R4 half read", got_data, ref_pick(w, 1, 2));
        access(1'b0, 7'h0C, 3'd4, 0);
        check(got_data == w, "R4 word read", got_data, w);
    endtask

    task automatic t_dma();
        logic [31:0] e;
        access(1'b1, 7'h48, 3'd4, 32'hA5A50000);
        check(dma_mem[2] == 32'hA5A50000, "R6 dma index 2", dma_mem[2], 32'hA5A50000);
        access(1'b1, 7'h5F, 3'd1, 32'h0000007E);
        e = ref_merge(32'h0, 32'h7E, 3, 1);
        check(dma_mem[7] == e, "R6 dma top byte", dma_mem[7], e);
        access(1'b0, 7'h4A, 3'd2, 0);
        check(got_data == 32'hA5A5, "R6 dma half read", got_data, 32'hA5A5);
    endtask

    task automatic t_ctrl();
        access(1'b1, 7'h70, 3'd4, 32'h11223344);
        check(got_rd == 0 && got_wr == 0, "R7 no bank strobe", 32'(got_rd + got_wr), 0);
        access(1'b1, 7'h72, 3'd1, 32'h000000AA);
        access(1'b0, 7'h70, 3'd4, 0);
        check(got_data == 32'h11AA3344, "R7 ctrl merge", got_data, 32'h11AA3344);
        access(1'b0, 7'h73, 3'd1, 0);
        check(got_data == 32'h11, "R7 ctrl byte read", got_data, 32'h11);
    endtask

    task automatic t_unmapped();
        access(1'b1, 7'h64, 3'd4, 32'hCAFECAFE);
        check(got_wr == 0, "R8 no write strobe", 32'(got_wr), 0);
        access(1'b0, 7'h64, 3'd4, 0);
        check(got_data == 0, "R8 read zero 0x64", got_data, 0);
        access(1'b1, 7'h74, 3'd2, 32'h9999);
        access(1'b0, 7'h7C, 3'd4, 0);
        check(got_data == 0, "R8 read zero 0x7C", got_data, 0);
        access(1'b0, 7'h70, 3'd4, 0);
        check(got_data == 32'h11AA3344, "R8 ctrl untouched", got_data, 32'h11AA3344);
    endtask

    task automatic t_errors();
        logic [31:0] w;
        w = core_mem[3];
        access(1'b1, 7'h0E, 3'd4, 32'h0);
        check(got_err && got_rd == 0 && got_wr == 0, "R9 crossing", {got_err, 31'(got_rd + got_wr)},
              32'h80000000);
        check(core_mem[3] == w, "R9 word unchanged", core_mem[3], w);
        access(1'b0, 7'h0C, 3'd3, 0);
        check(got_err && got_rd == 0, "R9 size three", {got_err, 31'(got_rd)}, 32'h80000000);
        access(1'b1, 7'h0B, 3'd2, 32'h0);
        check(got_err, "R9 half crossing", 32'(got_err), 1);
        access(1'b0, 7'h0C, 3'd4, 0);
        check(!got_err, "R9 err clears", 32'(got_err), 0);
    endtask

    task automatic t_busy();
        int wr0 = wr_total;
        int b0  = busy_total;
        logic [31:0] w0;
        w0 = core_mem[0];
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 7'h11; req_size = 3'd1;
        req_wdata = 32'h66;
        @(negedge clk);
        check(busy, "R10 busy after accept", 32'(busy), 1);
        req_addr = 7'h00; req_size = 3'd4; req_wdata = 32'hFFFFFFFF;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid && !busy, "R10 rsp ends busy", {rsp_valid, busy}, 2);
        @(negedge clk);
        check(wr_total - wr0 == 1, "R10 one write", 32'(wr_total - wr0), 1);
        check(busy_total - b0 == 2, "R10 busy length", 32'(busy_total - b0), 2);
        check(core_mem[0] == w0, "R10 collision ignored", core_mem[0], w0);
        check(core_mem[4] == 32'h6600, "R10 first req applied", core_mem[4], 32'h6600);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_write();
        t_narrow_write();
        t_reads();
        t_dma();
        t_ctrl();
        t_unmapped();
        t_errors();
        t_busy();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule